// File: doc/BRIEF.md
# Multi-Slot Compare Event Generator

This block sits beside a free-running, wrapping count-up counter and turns it into a source of one-shot events. It holds a bank of compare slots. Each slot raises its own status bit when the running count equals the slot's programmed value. One counter can therefore serve as a timestamp for software and also as an event timer. The counter itself is never reset or reloaded.

To schedule an event, software reads the count, adds the wanted delay with ordinary wrap-around arithmetic, writes the sum into a free slot, and enables that slot. The match fires on equality, so a target that lies beyond the wrap through zero is reached in the normal way. The status bits stay set until software clears them, and a single interrupt line reports that at least one status bit is set. The counter must advance by exactly one per tick, so delays run from 1 up to 0xFFFFFFFE ticks.

Top module: `cmp_event_unit`

## Requirements
- R1: After reset every compare slot reads 0, the enable register and the status register read 0, `cmpStatus` is 0 and `cmpIrq` is low.
- R2: Slot i's 32-bit compare value is written and read back at byte address 0x60 + 4*i, for i = 0..7, and a write to one slot leaves the others unchanged.
- R3: Bit i of the enable register (address 0x40) enables slot i. Bit i of the status register (address 0x44) mirrors `cmpStatus[i]`. Both registers read back in bits 7:0 with bits 31:8 zero.
- R4: When `count` equals an enabled slot's compare value, that slot's status bit is set on the following clock edge and is visible at the port after it.
- R5: Matching is a full 32-bit equality. A target that wrapped past zero (for example count 0xFFFFFFFF plus delay 2 gives 1) matches after the counter wraps. The maximum delay of 0xFFFFFFFE ticks lands on count minus 2.
- R6: A status bit stays set until a write to 0x44 with a 1 in that bit position. Writing 0 to a bit leaves it unchanged.
- R7: A status bit is set once per equality event. While `count` stays equal to the compare value over several cycles, the bit is not set again after being cleared. It fires again only after the count has left the value and returned to it.
- R8: A disabled slot never sets its status bit. Enabling a slot while the count already equals its value does not fire it.
- R9: `cmpIrq` is high exactly while at least one status bit is set.
- R10: If a match and a clear of the same bit fall on the same clock edge, the bit ends up set.
- R11: A write to an address outside 0x40, 0x44 and 0x60..0x7C changes no register. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe, one cycle per write |
| addr | input | 8 | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| count | input | 32 | Value of the free-running counter |
| cmpStatus | output | 8 | Per-slot status bits |
| cmpIrq | output | 1 | Compare interrupt, high while any status bit is set |

## Verification
The bench builds the block with its default 32-bit count and eight slots. The count is a port driven directly by the bench, so the wrap from 0xFFFFFFFF to 0, the top of the range and the largest delay can all be reached in a few cycles, with no need to wait 2^32 ticks. Holding `count` still over many cycles exposes the once-per-event rule. Moving a count onto the target in the same cycle as a status-clear write exposes the ordering between set and clear.

// File: rtl/cmp_event_pkg.sv
package cmp_event_pkg;
  localparam int NUM_SLOTS = 8;
  localparam int ADDR_W    = 8;
  localparam int STRIDE    = 4;
  localparam logic [ADDR_W-1:0] CMP_BASE = 8'h60;
  localparam logic [ADDR_W-1:0] EN_ADDR  = 8'h40;
  localparam logic [ADDR_W-1:0] STS_ADDR = 8'h44;

  // Write strobes handed from the decode logic to the datapath.
  typedef struct packed {
    logic [NUM_SLOTS-1:0] cmpWr;
    logic                 enWr;
    logic                 stsClr;
  } strobe_t;
endpackage

// File: rtl/cmp_event_ctrl.sv
module cmp_event_ctrl
  import cmp_event_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             wrEn,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_SLOTS-1:0][CNT_W-1:0]  cmpBank,
  input  logic [NUM_SLOTS-1:0]             enMask,
  input  logic [NUM_SLOTS-1:0]             status,
  output strobe_t                          stb,
  output logic [CNT_W-1:0]                 rdData
);
  logic [NUM_SLOTS-1:0] slotSel;
  logic                 enSel;
  logic                 stsSel;

  // One address comparator per compare slot.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSel
    assign slotSel[g] = (addr == CMP_BASE + ADDR_W'(STRIDE * g));
  end

  assign enSel  = (addr == EN_ADDR);
  assign stsSel = (addr == STS_ADDR);

  always_comb begin
    stb.cmpWr  = wrEn ? slotSel : '0;
    stb.enWr   = wrEn && enSel;
    stb.stsClr = wrEn && stsSel;
  end

  always_comb begin
    rdData = '0;
    if (enSel)  rdData[NUM_SLOTS-1:0] = enMask;
    if (stsSel) rdData[NUM_SLOTS-1:0] = status;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slotSel[i]) rdData = cmpBank[i];
    end
  end
endmodule

// File: rtl/cmp_event_datapath.sv
module cmp_event_datapath
  import cmp_event_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  input  logic [CNT_W-1:0]                 wrData,
  input  logic [CNT_W-1:0]                 count,
  output logic [NUM_SLOTS-1:0][CNT_W-1:0]  cmpBank,
  output logic [NUM_SLOTS-1:0]             enMask,
  output logic [NUM_SLOTS-1:0]             status
);
  logic [NUM_SLOTS-1:0] eqNow;
  logic [NUM_SLOTS-1:0] eqPrev;
  logic [NUM_SLOTS-1:0] hit;
  logic [NUM_SLOTS-1:0] clrMask;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gEq
    assign eqNow[g] = (count == cmpBank[g]);
  end

  // A hit is the first cycle of equality on an enabled slot.
  assign hit     = enMask & eqNow & ~eqPrev;
  assign clrMask = stb.stsClr ? wrData[NUM_SLOTS-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpBank <= '0;
      enMask  <= '0;
      status  <= '0;
      eqPrev  <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (stb.cmpWr[i]) cmpBank[i] <= wrData;
      end
      if (stb.enWr) enMask <= wrData[NUM_SLOTS-1:0];
      status <= (status & ~clrMask) | hit;
      eqPrev <= eqNow;
    end
  end
endmodule

// File: rtl/cmp_event_unit.sv
module cmp_event_unit
  import cmp_event_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [CNT_W-1:0]      wrData,
  output logic [CNT_W-1:0]      rdData,
  input  logic [CNT_W-1:0]      count,
  output logic [NUM_SLOTS-1:0]  cmpStatus,
  output logic                  cmpIrq
);
  strobe_t                           stb;
  logic [NUM_SLOTS-1:0][CNT_W-1:0]   cmpBank;
  logic [NUM_SLOTS-1:0]              enMask;

  cmp_event_ctrl #(.CNT_W(CNT_W)) ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .cmpBank (cmpBank),
    .enMask  (enMask),
    .status  (cmpStatus),
    .stb     (stb),
    .rdData  (rdData)
  );

  cmp_event_datapath #(.CNT_W(CNT_W)) dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .count   (count),
    .cmpBank (cmpBank),
    .enMask  (enMask),
    .status  (cmpStatus)
  );

  assign cmpIrq = |cmpStatus;
endmodule

// File: rtl/cmp_event_checker.sv
module cmp_event_checker
  import cmp_event_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     addr,
  input logic [CNT_W-1:0]      count,
  input logic [NUM_SLOTS-1:0]  cmpStatus,
  input logic [NUM_SLOTS-1:0]  enMask,
  input logic                  cmpIrq
);
  logic [1:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // R1: outputs are quiet while reset is held
  always @(posedge clk) begin
    if (!rstN) assert_reset_quiet_R1: assert (cmpStatus == '0 && !cmpIrq);
  end

  // R6: without a status write, no set bit drops
  assert_sticky_status_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && !$past(wrEn && addr == STS_ADDR)) |-> (($past(cmpStatus) & ~cmpStatus) == '0));

  // R8: a newly set bit must have been enabled when it was set
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0) |-> ((cmpStatus & ~$past(cmpStatus) & ~$past(enMask)) == '0));

  // R7: a count that did not move and an unchanged bank give no new bit
  assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cyc == 2'd3 && $past(count, 2) == $past(count) && !$past(wrEn, 2))
      |-> ((cmpStatus & ~$past(cmpStatus)) == '0));

  // R9: the interrupt rises only through an enabled slot
  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cyc != 2'd0 && $rose(cmpIrq)) |-> ($past(enMask) != '0));
endmodule

bind cmp_event_unit cmp_event_checker #(.CNT_W(CNT_W)) chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .addr      (addr),
  .count     (count),
  .cmpStatus (cmpStatus),
  .enMask    (enMask),
  .cmpIrq    (cmpIrq)
);

// File: tb/cmp_event_unit_test.sv
`timescale 1ns/1ps
module cmp_event_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] cnt = '0;
  logic [7:0]  cmpStatus;
  logic        cmpIrq;

  int errors = 0;
  int checks = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  cmp_event_unit uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .count(cnt), .cmpStatus(cmpStatus), .cmpIrq(cmpIrq)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [31:0] target;
    logic [31:0] start;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{3'd0, 32'h0000_0100, 32'h0000_00FE},   // R4 plain match
    '{3'd3, 32'h0000_0001, 32'hFFFF_FFFF},   // R5 target wrapped past zero
    '{3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFD},   // R5 top of range
    '{3'd5, 32'h0000_000E, 32'h0000_000C},   // R5 max delay 0xFFFFFFFE from 0x10
    '{3'd6, 32'h8000_0000, 32'h7FFF_FFFE}    // R4 mid-range
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdData;
    tick();
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 status port", {24'b0, cmpStatus}, 32'h0);
    check("R1 irq", {31'b0, cmpIrq}, 32'h0);
    rstN = 1'b1;
    tick();
    regRead(8'h40, rd); check("R1 enable reg", rd, 32'h0);
    regRead(8'h44, rd); check("R1 status reg", rd, 32'h0);
    regRead(8'h6C, rd); check("R1 slot3 value", rd, 32'h0);

    // R2 write and read back all slots
    for (int i = 0; i < 8; i++) regWrite(8'h60 + 8'(4 * i), 32'hA5A5_0000 + 32'(i * 17));
    for (int i = 0; i < 8; i++) begin
      regRead(8'h60 + 8'(4 * i), rd);
      check("R2 slot readback", rd, 32'hA5A5_0000 + 32'(i * 17));
    end

    // R11 unmapped accesses
    regWrite(8'h80, 32'hFFFF_FFFF);
    regWrite(8'h5C, 32'hFFFF_FFFF);
    regRead(8'h80, rd); check("R11 unmapped read", rd, 32'h0);
    regRead(8'h60, rd); check("R11 slot0 untouched", rd, 32'hA5A5_0000);
    regRead(8'h7C, rd); check("R11 slot7 untouched", rd, 32'hA5A5_0000 + 32'd119);
    regRead(8'h40, rd); check("R11 enable untouched", rd, 32'h0);

    // Vector table: R3, R4, R5
    for (int v = 0; v < 5; v++) begin
      regWrite(8'h60 + 8'(4 * VEC[v].slot), VEC[v].target);
      regWrite(8'h40, 32'(1) << VEC[v].slot);
      regRead(8'h40, rd); check("R3 enable readback", rd, 32'(1) << VEC[v].slot);
      for (int k = 0; k < 4; k++) begin
        cnt = VEC[v].start + 32'(k);
        tick();
        if (k == 0) check("R4 no early status", {24'b0, cmpStatus}, 32'h0);
      end
      check("R4 R5 status after match", {24'b0, cmpStatus}, 32'(1) << VEC[v].slot);
      check("R9 irq with status", {31'b0, cmpIrq}, 32'h1);
      regRead(8'h44, rd); check("R3 status readback", rd, 32'(1) << VEC[v].slot);
      regWrite(8'h44, 32'hFF);
      check("R6 cleared", {24'b0, cmpStatus}, 32'h0);
    end

    // R6 write 0 leaves bit, write 1 clears
    regWrite(8'h60, 32'h0000_0300);
    regWrite(8'h40, 32'h01);
    cnt = 32'h2FF; tick(); cnt = 32'h300; tick(); cnt = 32'h301; tick();
    regWrite(8'h44, 32'hFE);
    check("R6 zero write keeps bit", {24'b0, cmpStatus}, 32'h01);
    tick(); tick();
    check("R6 bit stays set", {24'b0, cmpStatus}, 32'h01);

    // R10 set wins over clear on the same edge
    cnt = 32'h300;
    regWrite(8'h44, 32'h01);
    check("R10 set beats clear", {24'b0, cmpStatus}, 32'h01);
    cnt = 32'h301; tick();
    regWrite(8'h44, 32'h01);
    check("R6 one write clears", {24'b0, cmpStatus}, 32'h0);

    // R7 held count fires once
    regWrite(8'h64, 32'h0000_0500);
    regWrite(8'h40, 32'h02);
    cnt = 32'h4FF; tick(); cnt = 32'h500; tick();
    tick(); tick(); tick();
    check("R7 set on equality", {24'b0, cmpStatus}, 32'h02);
    regWrite(8'h44, 32'h02);
    tick(); tick(); tick();
    check("R7 no refire while held", {24'b0, cmpStatus}, 32'h0);
    cnt = 32'h501; tick(); cnt = 32'h500; tick();
    check("R7 fires on return", {24'b0, cmpStatus}, 32'h02);
    regWrite(8'h44, 32'hFF);

    // R8 disabled slot, enabling while equal
    regWrite(8'h68, 32'h0000_0700);
    regWrite(8'h40, 32'h00);
    cnt = 32'h6FF; tick(); cnt = 32'h700; tick(); tick();
    check("R8 disabled no status", {24'b0, cmpStatus}, 32'h0);
    regWrite(8'h40, 32'h04);
    tick(); tick();
    check("R8 enable while equal no fire", {24'b0, cmpStatus}, 32'h0);
    cnt = 32'h701; tick(); cnt = 32'h700; tick();
    check("R8 enabled slot fires", {24'b0, cmpStatus}, 32'h04);
    regWrite(8'h44, 32'hFF);

    // R9 irq tracks any set bit
    regWrite(8'h60, 32'h0000_0900);
    regWrite(8'h70, 32'h0000_0901);
    regWrite(8'h40, 32'h11);
    cnt = 32'h8FF; tick(); cnt = 32'h900; tick(); cnt = 32'h901; tick(); cnt = 32'h902; tick();
    check("R9 two bits set", {24'b0, cmpStatus}, 32'h11);
    regWrite(8'h44, 32'h01);
    check("R9 irq with one bit left", {31'b0, cmpIrq}, 32'h1);
    check("R6 partial clear", {24'b0, cmpStatus}, 32'h10);
    regWrite(8'h44, 32'h10);
    check("R9 irq low when empty", {31'b0, cmpIrq}, 32'h0);

    finishRun();
  end
endmodule